// File: doc/BRIEF.md
# Microcoded Bus Datapath

This block is a small datapath with one shared internal bus and a table-driven sequencer. Two operand registers feed an ALU. The bus carries one value per cycle, taken from the input stream, the ALU result or an eight-word scratch RAM. The output stream shows the bus. Each control word in a constant ROM is one state row. It holds the next state and every datapath enable. For the conditional program, the signed-overflow bit of the register sum is appended to the ROM address as its least significant bit. This doubles the ROM and lets a loop exit depend on the data.

A parameter picks one of four built-in programs, and the ROM is computed from that choice at elaboration:

- a sum program producing 2A+B;
- a product program producing (A+B)(A-B), which parks A+B in RAM word 4;
- a repeated-add program that keeps emitting multiples of one input until the sum overflows;
- a memory-only program that adds RAM words 0 and 1 into word 2 and never touches the streams.

Both streams use valid/ready. `in_ready` is high exactly in states that take input, and it never depends on `in_valid`. `out_valid` is high exactly in states that emit a result, and it never depends on `out_ready`. A transfer happens on a rising edge where valid and ready are both high. If the present row needs an input that is not valid, or emits an output that is not accepted, the cycle is frozen: the state, the registers and the RAM all keep their values, so the offered output stays unchanged until it is taken.

Top module: `mbd_datapath`

## Requirements
- R1: A synchronous active-high reset puts the state to 0, clears both operand registers, and loads RAM word i with RAM_SEED*(i+1) truncated to WIDTH bits. After reset the sum program shows in_ready=1 and out_valid=0.
- R2: No control row enables more than one of input pass, ALU pass and RAM read. A row with no bus source leaves the bus at zero.
- R3: When the present row takes input and in_valid is low, or emits output and out_ready is low, nothing updates. A stalled out_valid stays high with out_data unchanged until it is accepted.
- R4: The sum program takes A and then B over two transfers and emits (2A+B) mod 2^WIDTH three edges after A is accepted. It then returns to waiting for a new A.
- R5: The product program takes A and B and emits ((A+B)*(A-B)) mod 2^WIDTH. The ALU function codes are 3'b011 add, 3'b010 subtract and 3'b110 multiply (low WIDTH bits); any other code gives zero.
- R6: The repeated-add program loads one input value A into both registers. It then emits X+A and sets X to that sum every cycle. After emitting the first sum with signed two's-complement overflow, it goes back to waiting for input.
- R7: The memory-only program repeats a three-state loop: RAM[0] onto the bus into X, RAM[1] into Y, then X+Y written to RAM[2]. in_ready and out_valid stay low throughout.
- R8: out_data always equals the bus, including cycles where out_valid is low. In the sum program, the cycle after B is accepted shows A+B with out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | WIDTH | Input stream data |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | High in states that take input |
| out_data | output | WIDTH | Present bus value |
| out_valid | output | 1 | High in states that emit a result |
| out_ready | input | 1 | Output stream accept |
| seq_state | output | 3 | Present-state register of the sequencer |

## Verification
A wrong state register or a wrong ROM row shows up at `seq_state` and on the streams within one cycle: `in_ready` or `out_valid` rises in the wrong cycle, or the program's period changes. A wrong operand register, ALU function or RAM content appears on `out_data` in the very next bus cycle that uses it. For the product program that can be three states later, when RAM word 4 is read back. A wrong overflow bit shows up as one output too many or too few in a repeated-add run.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  localparam int ST_W = 3;
  localparam int RA_W = 3;

  localparam int PRG_SUM_TWICE = 0;
  localparam int PRG_SQDIFF    = 1;
  localparam int PRG_REPEAT    = 2;
  localparam int PRG_MEMADD    = 3;

  typedef enum logic [2:0] {
    ALU_NONE = 3'b000,
    ALU_SUB  = 3'b010,
    ALU_ADD  = 3'b011,
    ALU_MUL  = 3'b110
  } alu_fn_e;

  // Row layout, most significant field first.
  typedef struct packed {
    logic [ST_W-1:0] nxt;
    alu_fn_e         fn;
    logic            ld_x;
    logic            ld_y;
    logic            drv_in;
    logic            drv_alu;
    logic            drv_out;
    logic [RA_W-1:0] ram_a;
    logic            ram_rd;
    logic            ram_wr;
  } uword_t;

  // mv = {ld_x, ld_y, drv_in, drv_alu, drv_out}, rw = {ram_rd, ram_wr}
  function automatic uword_t urow(input int nxt, input alu_fn_e fn,
                                  input logic [4:0] mv, input int adr,
                                  input logic [1:0] rw);
    uword_t w;
    w.nxt = ST_W'(nxt);
    w.fn = fn;
    {w.ld_x, w.ld_y, w.drv_in, w.drv_alu, w.drv_out} = mv;
    w.ram_a = RA_W'(adr);
    {w.ram_rd, w.ram_wr} = rw;
    return w;
  endfunction

  function automatic uword_t prog_row(input int prog, input int st, input logic cond);
    uword_t w;
    w = '0;
    case (prog)
      PRG_SUM_TWICE:
        case (st)
          0: w = urow(1, ALU_NONE, 5'b10100, 0, 2'b00);
          1: w = urow(2, ALU_NONE, 5'b01100, 0, 2'b00);
          2: w = urow(3, ALU_ADD,  5'b01010, 0, 2'b00);
          3: w = urow(0, ALU_ADD,  5'b00011, 0, 2'b00);
          default: w = '0;
        endcase
      PRG_SQDIFF:
        case (st)
          0: w = urow(1, ALU_NONE, 5'b10100, 0, 2'b00);
          1: w = urow(2, ALU_NONE, 5'b01100, 0, 2'b00);
          2: w = urow(3, ALU_ADD,  5'b00010, 4, 2'b01);
          3: w = urow(4, ALU_SUB,  5'b10010, 0, 2'b00);
          4: w = urow(5, ALU_NONE, 5'b01000, 4, 2'b10);
          5: w = urow(0, ALU_MUL,  5'b00011, 0, 2'b00);
          default: w = '0;
        endcase
      PRG_REPEAT:
        case (st)
          0: w = urow(1, ALU_NONE, 5'b11100, 0, 2'b00);
          1: w = urow(cond ? 0 : 1, ALU_ADD, 5'b10011, 0, 2'b00);
          default: w = '0;
        endcase
      PRG_MEMADD:
        case (st)
          0: w = urow(1, ALU_NONE, 5'b10000, 0, 2'b10);
          1: w = urow(2, ALU_NONE, 5'b01000, 1, 2'b10);
          2: w = urow(0, ALU_ADD,  5'b00010, 2, 2'b01);
          default: w = '0;
        endcase
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mbd_rom.sv
module mbd_rom
  import mbd_pkg::*;
#(
  parameter int PROGRAM = PRG_SUM_TWICE,
  parameter int CB      = 0
) (
  input  logic [ST_W+CB-1:0] addr,
  output uword_t             word
);
  localparam int AW    = ST_W + CB;
  localparam int DEPTH = 1 << AW;

  uword_t tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign tbl[i] = prog_row(PROGRAM, i >> CB, (CB == 1) && ((i % 2) == 1));
  end

  assign word = tbl[addr];
endmodule

// File: rtl/mbd_seq.sv
module mbd_seq
  import mbd_pkg::*;
#(
  parameter int PROGRAM = PRG_SUM_TWICE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            status,
  output logic [ST_W-1:0] state,
  output uword_t          word
);
  localparam int CB = (PROGRAM == PRG_REPEAT) ? 1 : 0;
  localparam int AW = ST_W + CB;

  logic [AW-1:0] addr;

  if (CB == 1) begin : g_cond
    assign addr = {state, status};
  end else begin : g_plain
    logic unused_status;
    assign unused_status = status;
    assign addr = state;
  end

  mbd_rom #(.PROGRAM(PROGRAM), .CB(CB)) u_rom (
    .addr(addr),
    .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else if (adv) state <= word.nxt;
  end
endmodule

// File: rtl/mbd_alu.sv
module mbd_alu
  import mbd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  alu_fn_e          fn,
  output logic [WIDTH-1:0] res,
  output logic             add_ovf
);
  logic [WIDTH-1:0] sum;

  assign sum = x + y;
  assign add_ovf = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);

  always_comb begin
    case (fn)
      ALU_ADD: res = sum;
      ALU_SUB: res = x - y;
      ALU_MUL: res = x * y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mbd_scratch.sv
module mbd_scratch
  import mbd_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEED  = 8'h13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [RA_W-1:0]  addr,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rd
);
  localparam int DEPTH = 1 << RA_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(SEED * (i + 1));
    end else if (we) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];
endmodule

// File: rtl/mbd_datapath.sv
module mbd_datapath
  import mbd_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int PROGRAM  = PRG_SUM_TWICE,
  parameter int RAM_SEED = 8'h13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ST_W-1:0]  seq_state
);
  uword_t           uw;
  logic             adv;
  logic             add_ovf;
  logic [WIDTH-1:0] bus;
  logic [WIDTH-1:0] alu_res;
  logic [WIDTH-1:0] ram_q;
  logic [WIDTH-1:0] x_q;
  logic [WIDTH-1:0] y_q;

  mbd_seq #(.PROGRAM(PROGRAM)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .status(add_ovf),
    .state (seq_state),
    .word  (uw)
  );

  mbd_alu #(.WIDTH(WIDTH)) u_alu (
    .x      (x_q),
    .y      (y_q),
    .fn     (uw.fn),
    .res    (alu_res),
    .add_ovf(add_ovf)
  );

  mbd_scratch #(.WIDTH(WIDTH), .SEED(RAM_SEED)) u_ram (
    .clk (clk),
    .rst (rst),
    .we  (uw.ram_wr & adv),
    .addr(uw.ram_a),
    .wd  (bus),
    .rd  (ram_q)
  );

  // Stream handshake: ready/valid never look at their own partner.
  assign in_ready  = uw.drv_in  & (~uw.drv_out | out_ready);
  assign out_valid = uw.drv_out & (~uw.drv_in  | in_valid);
  assign adv = ~((uw.drv_in & ~in_valid) | (uw.drv_out & ~out_ready));

  // AND-OR bus: an idle row yields zero.
  assign bus = ({WIDTH{uw.drv_in}}  & in_data)
             | ({WIDTH{uw.drv_alu}} & alu_res)
             | ({WIDTH{uw.ram_rd}}  & ram_q);

  assign out_data = bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      if (uw.ld_x) x_q <= bus;
      if (uw.ld_y) y_q <= bus;
    end
  end
endmodule

// File: rtl/mbd_datapath_chk.sv
module mbd_datapath_chk
  import mbd_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int PROGRAM = PRG_SUM_TWICE
) (
  input logic             clk,
  input logic             rst,
  input uword_t           uw,
  input logic [ST_W-1:0]  seq_state,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             add_ovf
);
  assert_one_driver_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uw.drv_in, uw.drv_alu, uw.ram_rd}));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (seq_state == '0));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_in_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(seq_state));

  if (PROGRAM == PRG_REPEAT) begin : g_rep
    assert_ovf_exit_R6: assert property (@(posedge clk) disable iff (rst)
      (seq_state == 3'd1 && add_ovf && out_ready) |=> (seq_state == 3'd0));
    assert_loop_stay_R6: assert property (@(posedge clk) disable iff (rst)
      (seq_state == 3'd1 && !add_ovf && out_ready) |=> (seq_state == 3'd1));
  end else begin : g_norep
    logic unused_ovf;
    assign unused_ovf = add_ovf;
  end

  if (PROGRAM == PRG_MEMADD) begin : g_mem
    assert_no_stream_R7: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && !out_valid));
  end
endmodule

bind mbd_datapath mbd_datapath_chk #(.WIDTH(WIDTH), .PROGRAM(PROGRAM)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .uw       (uw),
  .seq_state(seq_state),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .add_ovf  (add_ovf)
);

// File: tb/sim_mbd_datapath.sv
module sim_mbd_datapath;
  localparam int W = 8;
  localparam int SEED = 8'h13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] ind  [4];
  logic         inv  [4];
  logic         inr  [4];
  logic [W-1:0] od   [4];
  logic         ov   [4];
  logic         ordy [4];
  logic [2:0]   st   [4];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  mbd_datapath #(.WIDTH(W), .PROGRAM(0), .RAM_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .in_data(ind[0]), .in_valid(inv[0]), .in_ready(inr[0]),
    .out_data(od[0]), .out_valid(ov[0]), .out_ready(ordy[0]), .seq_state(st[0]));
  mbd_datapath #(.WIDTH(W), .PROGRAM(1), .RAM_SEED(SEED)) u1 (
    .clk(clk), .rst(rst), .in_data(ind[1]), .in_valid(inv[1]), .in_ready(inr[1]),
    .out_data(od[1]), .out_valid(ov[1]), .out_ready(ordy[1]), .seq_state(st[1]));
  mbd_datapath #(.WIDTH(W), .PROGRAM(2), .RAM_SEED(SEED)) u2 (
    .clk(clk), .rst(rst), .in_data(ind[2]), .in_valid(inv[2]), .in_ready(inr[2]),
    .out_data(od[2]), .out_valid(ov[2]), .out_ready(ordy[2]), .seq_state(st[2]));
  mbd_datapath #(.WIDTH(W), .PROGRAM(3), .RAM_SEED(SEED)) u3 (
    .clk(clk), .rst(rst), .in_data(ind[3]), .in_valid(inv[3]), .in_ready(inr[3]),
    .out_data(od[3]), .out_valid(ov[3]), .out_ready(ordy[3]), .seq_state(st[3]));

  // {A, B} operand pairs
  localparam logic [15:0] VEC [8] = '{16'h0102, 16'h7F01, 16'hFF01, 16'h8080,
                                      16'h4040, 16'h00FF, 16'h5A3C, 16'hC3A5};

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic push(input int k, input logic [W-1:0] v);
    ind[k] = v;
    inv[k] = 1'b1;
    while (!inr[k]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inv[k] = 1'b0;
  endtask

  task automatic pull(input int k, output logic [W-1:0] v);
    while (!ov[k]) @(negedge clk);
    v = od[k];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_repeat(input logic [W-1:0] a, input int n_exp);
    logic [W-1:0] acc, sum, got;
    logic ovf;
    int n;
    acc = a;
    n = 0;
    ovf = 1'b0;
    push(2, a);
    while (!ovf && n < 300) begin
      pull(2, got);
      sum = acc + a;
      ovf = (acc[W-1] == a[W-1]) && (sum[W-1] != acc[W-1]);
      check("R6 repeated sum", got, sum);
      acc = sum;
      n++;
    end
    check("R6 output count", W'(n), W'(n_exp));
    check("R6 back to input state", W'(st[2]), 8'd0);
    check("R6 in_ready after exit", W'(inr[2]), 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, got, held;
    for (int k = 0; k < 4; k++) begin
      ind[k] = '0;
      inv[k] = 1'b0;
      ordy[k] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 state after reset", W'(st[0]), 8'd0);
    check("R1 in_ready after reset", W'(inr[0]), 8'd1);
    check("R1 out_valid after reset", W'(ov[0]), 8'd0);
    check("R1 repeat prog state", W'(st[2]), 8'd0);

    // R7 memory-only loop, free running from reset
    for (int c = 0; c < 6; c++) begin
      check("R7 mem state", W'(st[3]), W'(c % 3));
      case (c % 3)
        0: check("R7 bus RAM0 (R1 init)", od[3], W'(SEED));
        1: check("R7 bus RAM1 (R1 init)", od[3], W'(SEED * 2));
        default: check("R7 bus sum", od[3], W'(SEED * 3));
      endcase
      check("R7 no in_ready", W'(inr[3]), 8'd0);
      check("R7 no out_valid", W'(ov[3]), 8'd0);
      @(negedge clk);
    end

    // R4, R5, R8 vector table
    for (int i = 0; i < 8; i++) begin
      a = VEC[i][15:8];
      b = VEC[i][7:0];
      push(0, a);
      push(0, b);
      check("R8 bus shows A+B", od[0], W'(a + b));
      check("R8 no valid mid-program", W'(ov[0]), 8'd0);
      pull(0, got);
      check("R4 sum program", got, W'(2 * a + b));
      push(1, a);
      push(1, b);
      pull(1, got);
      check("R5 product program", got, W'((a + b) * (a - b)));
    end

    // R3 output stall
    push(0, 8'h11);
    push(0, 8'h22);
    ordy[0] = 1'b0;
    @(negedge clk);
    held = od[0];
    check("R3 output offered", W'(ov[0]), 8'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R3 stall state", W'(st[0]), 8'd3);
      check("R3 stall data", od[0], held);
      check("R3 stall valid", W'(ov[0]), 8'd1);
    end
    ordy[0] = 1'b1;
    pull(0, got);
    check("R3 value after stall", got, 8'h44);

    // R3 input stall
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R3 wait for input", W'(st[0]), 8'd0);
      check("R3 no output while waiting", W'(ov[0]), 8'd0);
    end

    // R6 repeated add
    run_repeat(8'h20, 3);
    run_repeat(8'h30, 2);
    run_repeat(8'hF0, 8);
    run_repeat(8'h7F, 1);

    // R1 reset mid-program
    push(1, 8'h05);
    check("R1 u1 mid program", W'(st[1]), 8'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 u1 state cleared", W'(st[1]), 8'd0);
    check("R1 u3 state cleared", W'(st[3]), 8'd0);
    check("R1 u3 RAM0 restored", od[3], W'(SEED));
    push(1, 8'h07);
    push(1, 8'h03);
    pull(1, got);
    check("R5 after reset", got, 8'h28);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule